// File: doc/BRIEF.md
# Frame Chain Walker

The block walks a linked list of frame descriptors stored in a word-addressed synchronous RAM. The host pulses `go` with the word address of the first descriptor, and the block then visits one descriptor after another. For each one it fetches the link word and the status/size word, and checks that the host has handed the descriptor over. It then fetches count/address pairs one at a time and offers each pair as a fragment request on a valid/ready output. After the final fragment of a frame it writes the status word back with completion flags. It then follows the link to the next descriptor, or stops.

Descriptor layout, in words from the descriptor base `b`: `b+0` holds the link (the word address of the next descriptor, zero for none). `b+1` holds the status in bits 15:0 and the frame size in bytes in bits 31:16. Fragment `k` occupies `b+2+2k` (the count word) and `b+3+2k` (the fragment address). A count word carries the byte count in bits 23:0 and a final-fragment marker in bit 31. In the status half-word, bits 13:12 equal to `11` mean "owned by the walker". Bit 14 means "frame complete", bit 11 means "end of chain" and bit 10 means "receive buffer too small".

The state machine has nine states. IDLE waits for `go`. LINK issues the link read. STAT issues the status read and captures the link. CHECK captures the status and decides whether the descriptor is owned: it goes to COUNT if so, and back to IDLE if not. COUNT issues the count read. ADDR issues the address read and captures the count. LOAD captures the address and computes the offered length. EMIT holds the request until `frag_ready`, then goes to COUNT for the next fragment or to WRITE after the final one. WRITE stores the status word, then goes to IDLE at the end of the chain or to LINK for the next descriptor. A `stop` pulse sends every state to IDLE on the next edge.

Top module: `frame_chain_walker`

## Requirements
- R1: After reset `busy`, `frag_valid`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: A descriptor at base `b` is read as link at `b`, then status/size at `b+1`, then for fragment k the count at `b+2+2k` and the address at `b+3+2k`.
- R3: If status bits 13:12 of a fetched descriptor are not `11`, the block offers no fragment and writes nothing for that descriptor. It pulses `chain_end` and returns to idle.
- R4: Fragments are offered in descriptor order, and each carries the fetched address and the count bits 23:0. `frag_addr`, `frag_len` and `frag_last` stay stable while `frag_valid` is high and `frag_ready` is low. No memory access occurs while a fragment is offered.
- R5: A count word with bit 31 set ends the frame at that fragment. Without it, the frame ends after the tenth fragment (MAX_FRAGS), and `frag_last` marks the final fragment either way.
- R6: With `one_frag` high at `go`, each descriptor yields exactly one fragment, with `frag_last` high whatever bit 31 holds. Descriptors may then be packed four words apart.
- R7: With `tx_mode` high at `go`, when the byte counts of a frame total less than 64, the final fragment's length is raised so that the frame totals exactly 64.
- R8: At the end of each frame the block writes `b+1` exactly once. Bits 31:16 and the other status bits stay as fetched, and bit 14 is set. Bit 11 is set when the chain ends at this descriptor. Bit 10 is set in receive mode (`tx_mode` low) when the frame size exceeds the summed counts. `frame_done` pulses in the same cycle.
- R9: After the write-back the walk continues at the link address. It ends, with a `chain_end` pulse, when the link is zero or when the fetched status already had bit 11 set.
- R10: A `stop` pulse returns the block to idle on the next clock, with no further memory access and no write-back.
- R11: `go` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start strobe, taken in idle only |
| stop | input | 1 | Abort strobe |
| start_ptr | input | AW | Word address of the first descriptor |
| tx_mode | input | 1 | Transmit mode (padding on), sampled at go |
| one_frag | input | 1 | Single-fragment descriptors, sampled at go |
| busy | output | 1 | High while a walk is in progress |
| mem_rd_en | output | 1 | RAM read strobe, data on the next cycle |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_addr | output | AW | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data |
| frag_valid | output | 1 | Fragment request valid |
| frag_ready | input | 1 | Fragment request accepted |
| frag_addr | output | 32 | Fragment address |
| frag_len | output | LEN_W | Fragment byte count |
| frag_last | output | 1 | Final fragment of the frame |
| frame_done | output | 1 | One-cycle pulse on status write-back |
| chain_end | output | 1 | One-cycle pulse when the walk ends |

## Verification
The assertions check four things on every cycle: that a stalled fragment holds its fields, that no memory traffic overlaps an offered fragment, that every write-back carries the completion bit, and that a stop empties the machine. The exact fragment sequence, the padded lengths, the chain-end and receive-error bits, and the link-following order can only be shown by the bench's scenarios. Those scenarios sweep one to ten fragments in both modes, and cover the capped frame, packed one-fragment chains, unowned descriptors, host-marked chain ends, stop and a repeated go.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LINK,
        ST_STAT,
        ST_CHECK,
        ST_COUNT,
        ST_ADDR,
        ST_LOAD,
        ST_EMIT,
        ST_WRITE
    } fcw_state_e;

    // status half-word bit positions
    localparam int unsigned BIT_DONE   = 14;
    localparam int unsigned BIT_OWN_HI = 13;
    localparam int unsigned BIT_OWN_LO = 12;
    localparam int unsigned BIT_EOC    = 11;
    localparam int unsigned BIT_RXERR  = 10;

    // count word final-fragment marker
    localparam int unsigned BIT_CNT_LAST = 31;

    localparam logic [1:0] OWN_CODE = 2'b11;

endpackage

// File: rtl/fcw_addr_gen.sv
module fcw_addr_gen
    import fcw_pkg::*;
#(
    parameter int AW    = 16,
    parameter int IDX_W = 4
) (
    input  fcw_state_e       state,
    input  logic [AW-1:0]    base,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);

    localparam int PAIR_START = 2;

    logic [AW-1:0] pair_ofs;

    assign pair_ofs = AW'(PAIR_START) + AW'({idx, 1'b0});

    always_comb begin
        unique case (state)
            ST_STAT, ST_WRITE: addr = base + AW'(1);
            ST_COUNT:          addr = base + pair_ofs;
            ST_ADDR:           addr = base + pair_ofs + AW'(1);
            default:           addr = base;
        endcase
    end

endmodule

// File: rtl/fcw_pad_calc.sv
module fcw_pad_calc #(
    parameter int LEN_W     = 24,
    parameter int TOT_W     = 28,
    parameter int MIN_FRAME = 64
) (
    input  logic [LEN_W-1:0] raw_len,
    input  logic [TOT_W-1:0] total_in,
    input  logic             pad_en,
    output logic [LEN_W-1:0] len_out,
    output logic [TOT_W-1:0] total_out
);

    localparam logic [TOT_W-1:0] MIN_T = TOT_W'(MIN_FRAME);

    logic short_frame;

    assign total_out   = total_in + TOT_W'(raw_len);
    assign short_frame = pad_en && (total_out < MIN_T);
    assign len_out     = short_frame ? raw_len + LEN_W'(MIN_T - total_out) : raw_len;

endmodule

// File: rtl/fcw_status_merge.sv
module fcw_status_merge
    import fcw_pkg::*;
#(
    parameter int TOT_W = 28
) (
    input  logic [15:0]      status_in,
    input  logic [15:0]      size_in,
    input  logic [TOT_W-1:0] total,
    input  logic             final_desc,
    input  logic             rx_mode,
    output logic [31:0]      word_out
);

    logic        rx_short;
    logic [15:0] merged;

    assign rx_short = rx_mode && (TOT_W'(size_in) > total);

    always_comb begin
        merged           = status_in;
        merged[BIT_DONE] = 1'b1;
        if (final_desc) merged[BIT_EOC]   = 1'b1;
        if (rx_short)   merged[BIT_RXERR] = 1'b1;
        word_out = {size_in, merged};
    end

endmodule

// File: rtl/frame_chain_walker.sv
module frame_chain_walker
    import fcw_pkg::*;
#(
    parameter int AW        = 16,
    parameter int MAX_FRAGS = 10,
    parameter int LEN_W     = 24,
    parameter int MIN_FRAME = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             stop,
    input  logic [AW-1:0]    start_ptr,
    input  logic             tx_mode,
    input  logic             one_frag,
    output logic             busy,
    output logic             mem_rd_en,
    output logic             mem_wr_en,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    output logic             frag_valid,
    input  logic             frag_ready,
    output logic [31:0]      frag_addr,
    output logic [LEN_W-1:0] frag_len,
    output logic             frag_last,
    output logic             frame_done,
    output logic             chain_end
);

    localparam int IDX_W = (MAX_FRAGS > 1) ? $clog2(MAX_FRAGS) : 1;
    localparam int TOT_W = LEN_W + IDX_W;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_FRAGS - 1);

    fcw_state_e state_q, state_d;

    logic [AW-1:0]    base_q;
    logic [AW-1:0]    link_q;
    logic             link_null_q;
    logic [15:0]      stat_q;
    logic [15:0]      size_q;
    logic [IDX_W-1:0] idx_q;
    logic [TOT_W-1:0] total_q;
    logic             cnt_last_q;
    logic [LEN_W-1:0] cnt_len_q;
    logic [31:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic             last_q;
    logic             tx_q;
    logic             one_q;

    logic             desc_owned;
    logic             frag_is_last;
    logic             final_desc;
    logic [LEN_W-1:0] pad_len;
    logic [TOT_W-1:0] pad_total;

    assign desc_owned   = (mem_rdata[BIT_OWN_HI:BIT_OWN_LO] == OWN_CODE);
    assign frag_is_last = cnt_last_q || one_q || (idx_q == IDX_LAST);
    assign final_desc   = link_null_q || stat_q[BIT_EOC];

    fcw_addr_gen #(
        .AW   (AW),
        .IDX_W(IDX_W)
    ) u_addr_gen (
        .state(state_q),
        .base (base_q),
        .idx  (idx_q),
        .addr (mem_addr)
    );

    fcw_pad_calc #(
        .LEN_W    (LEN_W),
        .TOT_W    (TOT_W),
        .MIN_FRAME(MIN_FRAME)
    ) u_pad_calc (
        .raw_len  (cnt_len_q),
        .total_in (total_q),
        .pad_en   (tx_q && frag_is_last),
        .len_out  (pad_len),
        .total_out(pad_total)
    );

    fcw_status_merge #(
        .TOT_W(TOT_W)
    ) u_status_merge (
        .status_in (stat_q),
        .size_in   (size_q),
        .total     (total_q),
        .final_desc(final_desc),
        .rx_mode   (!tx_q),
        .word_out  (mem_wdata)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (go) state_d = ST_LINK;
                ST_LINK:  state_d = ST_STAT;
                ST_STAT:  state_d = ST_CHECK;
                ST_CHECK: state_d = desc_owned ? ST_COUNT : ST_IDLE;
                ST_COUNT: state_d = ST_ADDR;
                ST_ADDR:  state_d = ST_LOAD;
                ST_LOAD:  state_d = ST_EMIT;
                ST_EMIT:  if (frag_ready) state_d = last_q ? ST_WRITE : ST_COUNT;
                ST_WRITE: state_d = final_desc ? ST_IDLE : ST_LINK;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // descriptor and fragment holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q      <= '0;
            link_q      <= '0;
            link_null_q <= 1'b0;
            stat_q      <= '0;
            size_q      <= '0;
            idx_q       <= '0;
            total_q     <= '0;
            cnt_last_q  <= 1'b0;
            cnt_len_q   <= '0;
            addr_q      <= '0;
            len_q       <= '0;
            last_q      <= 1'b0;
            tx_q        <= 1'b0;
            one_q       <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (go && !stop) begin
                        base_q <= start_ptr;
                        tx_q   <= tx_mode;
                        one_q  <= one_frag;
                    end
                end
                ST_STAT: begin
                    link_null_q <= (mem_rdata == 32'h0);
                    link_q      <= mem_rdata[AW-1:0];
                end
                ST_CHECK: begin
                    stat_q  <= mem_rdata[15:0];
                    size_q  <= mem_rdata[31:16];
                    idx_q   <= '0;
                    total_q <= '0;
                end
                ST_ADDR: begin
                    cnt_last_q <= mem_rdata[BIT_CNT_LAST];
                    cnt_len_q  <= mem_rdata[LEN_W-1:0];
                end
                ST_LOAD: begin
                    addr_q  <= mem_rdata;
                    len_q   <= pad_len;
                    last_q  <= frag_is_last;
                    total_q <= pad_total;
                end
                ST_EMIT: begin
                    if (frag_ready && !last_q) idx_q <= idx_q + 1'b1;
                end
                ST_WRITE: base_q <= link_q;
                default: ;
            endcase
        end
    end

    // state-decoded outputs
    always_comb begin
        busy       = 1'b1;
        mem_rd_en  = 1'b0;
        mem_wr_en  = 1'b0;
        frag_valid = 1'b0;
        frame_done = 1'b0;
        chain_end  = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_LINK, ST_STAT, ST_COUNT, ST_ADDR: mem_rd_en = 1'b1;
            ST_CHECK: chain_end = !desc_owned;
            ST_LOAD:  ;
            ST_EMIT:  frag_valid = 1'b1;
            ST_WRITE: begin
                mem_wr_en  = 1'b1;
                frame_done = 1'b1;
                chain_end  = final_desc;
            end
            default:  busy = 1'b0;
        endcase
    end

    assign frag_addr = addr_q;
    assign frag_len  = len_q;
    assign frag_last = last_q;

endmodule

// File: rtl/fcw_checker.sv
module fcw_checker #(
    parameter int LEN_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stop,
    input logic             busy,
    input logic             mem_rd_en,
    input logic             mem_wr_en,
    input logic [31:0]      mem_wdata,
    input logic             frag_valid,
    input logic             frag_ready,
    input logic [31:0]      frag_addr,
    input logic [LEN_W-1:0] frag_len,
    input logic             frag_last,
    input logic             chain_end
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !frag_valid && !mem_rd_en && !mem_wr_en));

    assert_frag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && !frag_ready && !stop) |=>
        (frag_valid && $stable(frag_addr) && $stable(frag_len) && $stable(frag_last)));

    assert_no_mem_during_frag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (!mem_rd_en && !mem_wr_en));

    assert_wb_done_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wdata[14] && !mem_rd_en));

    assert_end_inside_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        chain_end |-> busy);

    assert_stop_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && busy) |=> (!busy && !mem_rd_en && !mem_wr_en));

endmodule

bind frame_chain_walker fcw_checker #(
    .LEN_W(LEN_W)
) u_fcw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop      (stop),
    .busy      (busy),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_wdata (mem_wdata),
    .frag_valid(frag_valid),
    .frag_ready(frag_ready),
    .frag_addr (frag_addr),
    .frag_len  (frag_len),
    .frag_last (frag_last),
    .chain_end (chain_end)
);

// File: tb/test_frame_chain_walker.sv
`timescale 1ns/1ps
module test_frame_chain_walker;

    localparam int AW        = 16;
    localparam int LW        = 24;
    localparam int MEM_WORDS = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          go = 1'b0;
    logic          stop = 1'b0;
    logic          tx_mode = 1'b0;
    logic          one_frag = 1'b0;
    logic          frag_ready = 1'b0;
    logic [AW-1:0] start_ptr = '0;
    logic          busy, mem_rd_en, mem_wr_en, frag_valid, frag_last, frame_done, chain_end;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, frag_addr;
    logic [31:0]   mem_rdata = 32'h0;
    logic [LW-1:0] frag_len;

    always #2.5 clk = ~clk;

    frame_chain_walker i_frame_chain_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .stop      (stop),
        .start_ptr (start_ptr),
        .tx_mode   (tx_mode),
        .one_frag  (one_frag),
        .busy      (busy),
        .mem_rd_en (mem_rd_en),
        .mem_wr_en (mem_wr_en),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .frag_valid(frag_valid),
        .frag_ready(frag_ready),
        .frag_addr (frag_addr),
        .frag_len  (frag_len),
        .frag_last (frag_last),
        .frame_done(frame_done),
        .chain_end (chain_end)
    );

    logic [31:0] mem [MEM_WORDS];

    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr[7:0]] = mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
    end

    int n_cmp = 0, n_bad = 0;
    int n_frag = 0, n_end = 0, n_done = 0;
    int ready_mode = 0, rcnt = 0;
    bit finished = 1'b0;
    logic [31:0] lg_addr [64];
    logic [LW-1:0] lg_len [64];
    logic lg_last [64];

    // ready generation and fragment logging, away from the active edge
    always @(negedge clk) begin
        rcnt++;
        case (ready_mode)
            0:       frag_ready = 1'b1;
            1:       frag_ready = (rcnt % 3 == 0);
            default: frag_ready = 1'b0;
        endcase
        if (rst_n) begin
            if (frag_valid && frag_ready) begin
                if (n_frag < 64) begin
                    lg_addr[n_frag] = frag_addr;
                    lg_len[n_frag]  = frag_len;
                    lg_last[n_frag] = frag_last;
                end
                n_frag++;
            end
            if (chain_end)  n_end++;
            if (frame_done) n_done++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
    endtask

    task automatic clear_log();
        n_frag = 0; n_end = 0; n_done = 0;
    endtask

    task automatic put_desc(input int b, input logic [31:0] link, input logic [15:0] sz,
                            input logic [15:0] st);
        mem[b]     = link;
        mem[b + 1] = {sz, st};
    endtask

    task automatic put_frag(input int b, input int k, input logic [31:0] cnt, input logic [31:0] ad);
        mem[b + 2 + 2 * k] = cnt;
        mem[b + 3 + 2 * k] = ad;
    endtask

    task automatic kick(input int p);
        @(negedge clk);
        start_ptr = AW'(p);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while (busy && t < 4000) begin
            @(negedge clk);
            t++;
        end
        if (busy) begin
            n_cmp++; n_bad++;
            $display("FAIL R9 walk timeout: actual busy 1 expected 0");
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int sum, exp_len;
        logic [15:0] sz, st;
        logic [31:0] orig;

        clear_mem();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 32'h0);
        chk("R1 frag_valid", 32'(frag_valid), 32'h0);
        chk("R1 mem_rd_en", 32'(mem_rd_en), 32'h0);
        chk("R1 mem_wr_en", 32'(mem_wr_en), 32'h0);

        // sweep: fragment count 1..10, receive and transmit
        for (int tx = 0; tx < 2; tx++) begin
            for (int n = 1; n <= 10; n++) begin
                clear_mem(); clear_log();
                tx_mode = tx[0]; one_frag = 1'b0; ready_mode = n % 2;
                sum = 0;
                for (int i = 0; i < n; i++) sum += 2 + 3 * i + n;
                sz = (n % 2 == 1) ? 16'(sum + 1) : 16'(sum);
                st = 16'h3021;
                put_desc(32, 32'h0, sz, st);
                for (int i = 0; i < n; i++)
                    put_frag(32, i, 32'(2 + 3 * i + n) | ((i == n - 1) ? 32'h8000_0000 : 32'h0),
                             32'hA000_0000 + 32'(tx << 16) + 32'(n << 8) + 32'(i * 4));
                kick(32);
                wait_idle();
                chk("R5 fragment count", 32'(n_frag), 32'(n));
                for (int i = 0; i < n; i++) begin
                    exp_len = 2 + 3 * i + n;
                    if (tx == 1 && i == n - 1 && sum < 64) exp_len += 64 - sum;
                    chk("R2 R4 fragment address", lg_addr[i],
                        32'hA000_0000 + 32'(tx << 16) + 32'(n << 8) + 32'(i * 4));
                    chk("R7 fragment length", 32'(lg_len[i]), 32'(exp_len));
                    chk("R4 last flag", 32'(lg_last[i]), 32'(i == n - 1));
                end
                chk("R8 status write-back", mem[33],
                    {sz, st | 16'h4800 | ((tx == 0 && n % 2 == 1) ? 16'h0400 : 16'h0)});
                chk("R9 chain_end pulses", 32'(n_end), 32'h1);
                chk("R8 frame_done pulses", 32'(n_done), 32'h1);
            end
        end
        tx_mode = 1'b0;

        // R5: ten-fragment cap, no marker anywhere
        clear_mem(); clear_log(); ready_mode = 0;
        put_desc(16, 32'h0, 16'h0, 16'h3000);
        for (int i = 0; i < 11; i++) put_frag(16, i, 32'(i + 1), 32'hC000_0000 + 32'(i));
        kick(16); wait_idle();
        chk("R5 capped count", 32'(n_frag), 32'd10);
        chk("R5 capped last", 32'(lg_last[9]), 32'h1);
        chk("R5 capped not last", 32'(lg_last[8]), 32'h0);
        chk("R5 capped status", mem[17], {16'h0, 16'h7800});

        // R5: marker on the third of five
        clear_mem(); clear_log();
        put_desc(64, 32'h0, 16'h0, 16'h3000);
        for (int i = 0; i < 5; i++)
            put_frag(64, i, 32'(i + 7) | ((i == 2) ? 32'h8000_0000 : 32'h0), 32'hD000_0000 + 32'(i));
        kick(64); wait_idle();
        chk("R5 early last count", 32'(n_frag), 32'd3);
        chk("R5 early last flag", 32'(lg_last[2]), 32'h1);
        chk("R5 early last len", 32'(lg_len[2]), 32'd9);

        // R6: packed single-fragment descriptors
        clear_mem(); clear_log(); one_frag = 1'b1;
        put_desc(64, 32'd68, 16'd10, 16'h3000);
        put_frag(64, 0, 32'd10, 32'hE000_0064);
        put_desc(68, 32'h0, 16'd10, 16'h3000);
        put_frag(68, 0, 32'd10, 32'hE000_0068);
        kick(64); wait_idle();
        one_frag = 1'b0;
        chk("R6 one-frag count", 32'(n_frag), 32'd2);
        chk("R6 first last flag", 32'(lg_last[0]), 32'h1);
        chk("R6 second addr", lg_addr[1], 32'hE000_0068);
        chk("R6 first status", mem[65], {16'd10, 16'h7000});
        chk("R6 second status", mem[69], {16'd10, 16'h7800});

        // R9: three-descriptor chain
        clear_mem(); clear_log();
        put_desc(16, 32'd64, 16'd17, 16'h3000);
        put_desc(64, 32'd128, 16'd17, 16'h3000);
        put_desc(128, 32'h0, 16'd17, 16'h3000);
        for (int d = 0; d < 3; d++) begin
            put_frag((d == 0) ? 16 : (d == 1) ? 64 : 128, 0, 32'd8, 32'hF000_0000 + 32'(d * 16));
            put_frag((d == 0) ? 16 : (d == 1) ? 64 : 128, 1, 32'h8000_0009, 32'hF000_0001 + 32'(d * 16));
        end
        kick(16); wait_idle();
        chk("R9 chain fragments", 32'(n_frag), 32'd6);
        chk("R9 chain order", lg_addr[4], 32'hF000_0020);
        chk("R9 first status", mem[17], {16'd17, 16'h7000});
        chk("R9 last status", mem[129], {16'd17, 16'h7800});
        chk("R9 frames", 32'(n_done), 32'd3);
        chk("R9 chain_end", 32'(n_end), 32'd1);

        // R9: host-marked end in the middle descriptor
        clear_log();
        put_desc(16, 32'd64, 16'd17, 16'h3000);
        put_desc(64, 32'd128, 16'd17, 16'h3800);
        put_desc(128, 32'h0, 16'd17, 16'h3000);
        kick(16); wait_idle();
        chk("R9 host end fragments", 32'(n_frag), 32'd4);
        chk("R9 host end status", mem[65], {16'd17, 16'h7800});
        chk("R9 untouched third", mem[129], {16'd17, 16'h3000});

        // R3: unowned descriptor
        clear_mem(); clear_log();
        put_desc(16, 32'h0, 16'd5, 16'h2000);
        put_frag(16, 0, 32'h8000_0005, 32'h1234_0000);
        kick(16); wait_idle();
        chk("R3 no fragments", 32'(n_frag), 32'h0);
        chk("R3 status unchanged", mem[17], {16'd5, 16'h2000});
        chk("R3 chain_end", 32'(n_end), 32'h1);
        chk("R3 no frame_done", 32'(n_done), 32'h0);

        // R3: owned then unowned
        clear_mem(); clear_log();
        put_desc(16, 32'd64, 16'd5, 16'h3000);
        put_frag(16, 0, 32'h8000_0005, 32'h1234_0010);
        put_desc(64, 32'h0, 16'd5, 16'h1000);
        put_frag(64, 0, 32'h8000_0005, 32'h1234_0040);
        kick(16); wait_idle();
        chk("R3 partial fragments", 32'(n_frag), 32'h1);
        chk("R3 first written", mem[17], {16'd5, 16'h7000});
        chk("R3 second untouched", mem[65], {16'd5, 16'h1000});

        // R10: stop while a fragment is stalled
        clear_mem(); clear_log(); ready_mode = 2;
        put_desc(16, 32'h0, 16'd4, 16'h3000);
        put_frag(16, 0, 32'd2, 32'h5500_0000);
        put_frag(16, 1, 32'h8000_0002, 32'h5500_0001);
        kick(16);
        for (int t = 0; t < 50 && !frag_valid; t++) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        chk("R10 idle after stop", 32'(busy), 32'h0);
        orig = 32'h0;
        for (int t = 0; t < 4; t++) begin
            @(negedge clk);
            orig = orig | 32'(mem_rd_en) | 32'(mem_wr_en);
        end
        chk("R10 no access after stop", orig, 32'h0);
        chk("R10 no fragment taken", 32'(n_frag), 32'h0);
        chk("R10 no write-back", mem[17], {16'd4, 16'h3000});

        // R11: second go while busy is ignored
        clear_mem(); clear_log(); ready_mode = 2;
        put_desc(16, 32'h0, 16'd3, 16'h3000);
        put_frag(16, 0, 32'h8000_0003, 32'h0000_AAAA);
        put_desc(128, 32'h0, 16'd3, 16'h3000);
        put_frag(128, 0, 32'h8000_0003, 32'h0000_BBBB);
        kick(16);
        repeat (8) @(negedge clk);
        kick(128);
        ready_mode = 0;
        wait_idle();
        chk("R11 one fragment", 32'(n_frag), 32'h1);
        chk("R11 first chain only", lg_addr[0], 32'h0000_AAAA);
        chk("R11 second untouched", mem[129], {16'd3, 16'h3000});
        chk("R11 one frame", 32'(n_done), 32'h1);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule